// File: doc/BRIEF.md
# Nine-bit serial display link master

This block drives a three-wire serial link toward a display controller whose
write frames are nine bits long: a data/command flag followed by one byte. It
generates the serial clock itself from the system clock, holds the clock low
when idle, and moves the outgoing line only while the clock is low. Reads are
a separate eight-bit sequence. They have no flag bit, and the input line is
captured at the end of each low phase, just before the clock rises.

The host issues one request at a time through a valid/ready handshake. The
request carries a write/read select, the flag, and the byte to send. When the
frame has finished, the block pulses a done flag for one cycle. For a read, the
captured byte is then available on a result port, which holds that value until
the next read completes. The serial clock period follows from two parameters,
the system clock rate and the target link rate (0.8 MHz by default). Every
high and every low phase lasts HALF = (CLK_HZ + SCK_HZ) / (2*SCK_HZ) system
clocks, which is 156 at the defaults.

Top module: `dc9_link_master`

## Requirements
- R1: A write frame presents the flag first and then the byte most significant bit first. Each of the nine bits is valid on `mosi` at the rising `sck` edge that carries it.
- R2: `sck` is low whenever no transfer is in progress, and `mosi` never changes in a cycle in which `sck` is high.
- R3: After the last bit of a write, `mosi` is 0 from the cycle in which `sck` falls, and it stays 0 while the block is idle.
- R4: A read captures eight `miso` bits, most significant first, each taken at the system clock edge where `sck` rises. The byte appears on `rd_byte` in the cycle in which `done` is high.
- R5: A write produces exactly 9 rising `sck` edges and a read exactly 8.
- R6: The first rising `sck` edge comes HALF system clocks after the accepting edge, and every later high or low phase within the frame lasts exactly HALF clocks.
- R7: `done` is a one-cycle pulse that is high in the cycle after `sck` falls for the last time. This is 2*HALF*n+1 cycles after the accepting edge, with n = 9 for a write and n = 8 for a read.
- R8: `req_ready` is low from acceptance until the done cycle. A request presented while it is low is ignored and produces no frame and no extra `done`.
- R9: `rd_byte` changes only when a read completes, and a write leaves it unchanged.
- R10: During reset, `sck` and `mosi` are 0, `req_ready` is 1, `done` is 0 and `rd_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request is taken on this cycle if valid |
| req_write | input | 1 | 1 = nine-bit write frame, 0 = eight-bit read |
| req_dc | input | 1 | Data/command flag sent as the first write bit |
| req_byte | input | 8 | Byte to send on a write |
| rd_byte | output | 8 | Result of the most recent read |
| done | output | 1 | One-cycle pulse when a frame finishes |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Every result is due at a fixed cycle count from the edge that accepts a
request. The first clock rise follows HALF cycles later, each later clock level
lasts HALF cycles, and `done` arrives 2*HALF*n+1 cycles after acceptance. The
driver records the acceptance cycle with each expected frame. The monitor
samples on the falling system clock edge, records bits at each `sck` rise, and
compares the edge times and the done time against those counts, using a cycle
counter the bench runs itself. The input-line model shifts its next bit only
after each `sck` fall, so a capture made one cycle early or late returns a
different byte.

// File: rtl/dc9_link_master.sv
module dc9_link_master #(
  parameter int CLK_HZ = 250_000_000,
  parameter int SCK_HZ = 800_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       req_dc,
  input  logic [7:0] req_byte,
  output logic [7:0] rd_byte,
  output logic       done,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int HALF = (CLK_HZ + SCK_HZ) / (2 * SCK_HZ);
  localparam int CW   = $clog2(HALF + 1);

  logic          busy, wr, fin;
  logic [CW-1:0] cnt;
  logic [3:0]    nbit;
  logic [8:0]    sh;
  wire  [3:0]    last = wr ? 4'd8 : 4'd7;

  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wr      <= 1'b0;
      fin     <= 1'b0;
      cnt     <= '0;
      nbit    <= '0;
      sh      <= '0;
      rd_byte <= '0;
      done    <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1;
          wr   <= req_write;
          sh   <= {req_dc, req_byte};
          mosi <= req_write & req_dc;
          cnt  <= '0;
          nbit <= '0;
          fin  <= 1'b0;
        end
      end else if (fin) begin
        fin  <= 1'b0;
        busy <= 1'b0;
        done <= 1'b1;
        if (!wr) rd_byte <= sh[7:0];
      end else if (cnt != CW'(HALF - 1)) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          if (!wr) sh <= {sh[7:0], miso};
        end else begin
          sck <= 1'b0;
          if (nbit == last) begin
            fin  <= 1'b1;
            mosi <= 1'b0;
          end else begin
            nbit <= nbit + 1'b1;
            if (wr) begin
              mosi <= sh[7];
              sh   <= {sh[7:0], 1'b0};
            end
          end
        end
      end
    end
  end
endmodule

module dc9_link_master_chk #(
  parameter int HALF = 156
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [7:0] rd_byte,
  input logic       done,
  input logic       sck,
  input logic       mosi
);
  logic        sck_d, wr_q;
  logic [3:0]  rises;
  int unsigned lvl;
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      wr_q  <= 1'b0;
      rises <= '0;
      lvl   <= 0;
    end else begin
      sck_d <= sck;
      if (accept) begin
        wr_q  <= req_write;
        rises <= '0;
      end else if (sck && !sck_d) begin
        rises <= rises + 1'b1;
      end
      lvl <= accept ? 1 : (sck != sck_d) ? 2 : lvl + 1;
    end
  end

  p_mosi_still_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  p_idle_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sck && !mosi));
  p_edge_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises == (wr_q ? 4'd9 : 4'd8)));
  p_phase_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $changed(sck)) |-> ($past(lvl) == HALF));
  p_done_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sck && $past(!sck) && $past(!req_ready)));
  p_ready_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(rd_byte) |-> (done && !wr_q));
endmodule

bind dc9_link_master dc9_link_master_chk #(.HALF(HALF)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rd_byte(rd_byte), .done(done), .sck(sck), .mosi(mosi)
);

// File: tb/test_dc9_link_master.sv
module test_dc9_link_master;
  localparam int HALF = 156;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_dc = 0, miso;
  logic [7:0] req_byte = 0;
  logic req_ready, done, sck, mosi;
  logic [7:0] rd_byte;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] dev_byte = 0;
  int dev_idx = 0;
  logic [7:0] last_read = 0;

  logic [9:0] exp_q[$];
  int         acc_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign miso = dev_byte[7 - (dev_idx > 7 ? 7 : dev_idx)];

  dc9_link_master i_dc9_link_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dc(req_dc), .req_byte(req_byte),
    .rd_byte(rd_byte), .done(done), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic xfer(input bit wr, input bit dc, input logic [7:0] b, input bit poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_dc = dc; req_byte = b; req_valid = 1;
    if (!wr) begin dev_byte = b; dev_idx = 0; end
    @(negedge clk);
    req_valid = 0;
    exp_q.push_back({wr, dc, b});
    acc_q.push_back(cyc);
    if (poke) begin
      repeat (50) @(negedge clk);
      chk(req_ready == 0, "R8 ready low while busy", req_ready, 0);
      req_write = !wr; req_dc = !dc; req_byte = ~b; req_valid = 1;
      repeat (20) @(negedge clk);
      req_valid = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3 * HALF) begin
      @(negedge clk);
      if (sck || done) begin
        chk(0, "R8 no activity after ignored request", {sck, done}, 0);
        break;
      end
    end
  endtask

  logic       sck_p = 0;
  int         rises = 0, last_chg = 0;
  logic [8:0] got = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sck != sck_p) begin
        if (exp_q.size() == 0) chk(0, "R2 sck moves while idle", sck, 0);
        else if (sck && rises == 0)
          chk(cyc - acc_q[0] == HALF, "R6 first rise delay", cyc - acc_q[0], HALF);
        else
          chk(cyc - last_chg == HALF, "R6 phase length", cyc - last_chg, HALF);
        last_chg = cyc;
        if (sck) begin
          rises++;
          got = {got[7:0], mosi};
        end else begin
          dev_idx++;
        end
      end
      sck_p = sck;
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          logic [9:0] e;
          int a, n;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          n = e[9] ? 9 : 8;
          chk(rises == n, "R5 rising edge count", rises, n);
          chk(cyc - a == 2 * HALF * n + 1, "R7 done timing", cyc - a, 2 * HALF * n + 1);
          chk(!sck && req_ready, "R7/R8 idle at done", {sck, req_ready}, 1);
          if (e[9]) begin
            chk(got == e[8:0], "R1 write frame bits", got, e[8:0]);
            chk(mosi == 0, "R3 mosi low after write", mosi, 0);
            chk(rd_byte == last_read, "R9 result held across write", rd_byte, last_read);
          end else begin
            chk(rd_byte == e[7:0], "R4 read byte", rd_byte, e[7:0]);
            last_read = e[7:0];
          end
        end
        rises = 0;
      end
      if (req_ready && exp_q.size() == 0 && mosi)
        chk(0, "R3 mosi low while idle", mosi, 0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sck == 0 && mosi == 0, "R10 lines low in reset", {sck, mosi}, 0);
    chk(req_ready == 1 && done == 0, "R10 ready/done in reset", {req_ready, done}, 2);
    chk(rd_byte == 0, "R10 rd_byte in reset", rd_byte, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sck == 0 && req_ready == 1, "R2 idle after reset", {sck, req_ready}, 1);
    xfer(1, 1, 8'hA5, 0);
    xfer(1, 0, 8'h3C, 0);
    xfer(1, 1, 8'h00, 0);
    xfer(1, 0, 8'hFF, 0);
    xfer(0, 0, 8'hC3, 0);
    xfer(1, 1, 8'h81, 0);
    xfer(0, 0, 8'h5A, 1);
    xfer(1, 0, 8'h7E, 1);
    xfer(0, 0, 8'h01, 0);
    xfer(0, 0, 8'h80, 0);
    xfer(1, 1, 8'h96, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule